// File: doc/BRIEF.md
# Asynchronous Host Register Bus Slave

This block connects an external microprocessor to an internal register array over an asynchronous bus with separate strobes. The host first puts an address on a 15-bit address input. It marks the address with an active-high latch strobe. It then runs a read or a write with an active-low read strobe or an active-low write strobe. The 8-bit data bus is bidirectional at the pins. Inside the block it is split into a data input, a data output and an output enable. The host has no clock to share with the block, so every strobe is brought into the local clock domain by a synchronizer before any decision is taken.

The register array sits beside the block on a plain port: address, write data, a write-enable pulse and read data. Read data is sampled a parameterised number of local clocks after the read is detected. An active-low ready output holds the host in its cycle until the access is complete. This makes the block insert as many wait states as the local clock and read latency require.

Top module: `ibus_regslave`

## Requirements
- R1: The latched address on `reg_addr` is taken from the address bus on the falling edge of `addr_latch`. It does not change while `addr_latch` stays low, even if the address bus changes at the same moment as the fall or later.
- R2: While `addr_latch` is held high, `reg_addr` follows the address bus, trailing it by three local clocks.
- R3: `host_data_oe` is 1 only during a read. Once ready is low, `host_data_out` carries the addressed register's contents. Three local clocks after `rd_strobe_n` returns high, `host_data_oe` is 0.
- R4: For a read, `host_ready_n` goes low exactly `RD_LAT`+3 local clocks after `rd_strobe_n` falls.
- R5: A write produces exactly one `reg_we` pulse, one clock wide. It occurs three local clocks after `wr_strobe_n` rises. `reg_wdata` and `reg_addr` then carry the data held while the strobe was low and the latched address, even if the data bus changes when the strobe rises.
- R6: During a write, `host_ready_n` goes low three local clocks after `wr_strobe_n` falls. For both reads and writes, it returns high three local clocks after the strobe is released.
- R7: If the read and write strobes are low at the same time, no `reg_we` pulse occurs, `host_data_oe` stays 0 and `host_ready_n` stays high. The target register keeps its old value.
- R8: During and right after reset, `host_ready_n` is 1, `host_data_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_latch | input | 1 | Active-high address latch strobe from host |
| rd_strobe_n | input | 1 | Active-low read strobe from host |
| wr_strobe_n | input | 1 | Active-low write strobe from host |
| host_addr | input | AW (15) | Host address bus |
| host_data_in | input | DW (8) | Data bus, input side |
| host_data_out | output | DW (8) | Data bus, output side |
| host_data_oe | output | 1 | Drive enable for the data bus |
| host_ready_n | output | 1 | Active-low ready to host |
| reg_addr | output | AW (15) | Latched address to register array |
| reg_wdata | output | DW (8) | Write data to register array |
| reg_we | output | 1 | One-clock write pulse to register array |
| reg_rdata | input | DW (8) | Read data from register array |

## Verification
Some properties are checked on every clock. The latched address stays still while the synchronized latch strobe is low. The bus is driven only after a synchronized read. Ready is low only while a strobe was active. Each write pulse is one clock wide, and no pulse follows a cycle in which the read strobe was active. Other behaviour only the bench scenarios can show: the exact clock counts of ready and write timing, the data returned for written values, the tracking of the address while the latch is open, and the clash of both strobes leaving the register array untouched.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_WAIT = 3'd1,
    ST_RD_DONE = 3'd2,
    ST_WR_ACT  = 3'd3,
    ST_CLASH   = 3'd4
  } bus_state_e;

  localparam int STROBE_CNT = 3;
  localparam int IDX_ALE    = 0;
  localparam int IDX_RD     = 1;
  localparam int IDX_WR     = 2;

endpackage

// File: rtl/hbs_strobe_sync.sv
module hbs_strobe_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] sync_out
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], raw_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[b]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/hbs_sample_hold.sv
module hbs_sample_hold #(
  parameter int   W        = 8,
  parameter int   STAGES   = 2,
  parameter logic OPEN_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         gate_lvl,
  output logic [W-1:0] held_out
);

  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q[s] <= '0;
      end else if (s == 0) begin
        pipe_q[s] <= bus_in;
      end else begin
        pipe_q[s] <= pipe_q[(s > 0) ? s-1 : 0];
      end
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (gate_lvl == OPEN_LVL) begin
      hold_d = pipe_q[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign held_out = hold_q;

endmodule

// File: rtl/hbs_bus_ctrl.sv
module hbs_bus_ctrl
  import hbs_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          ready_n,
  output logic          we
);

  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RD_LAT - 1);

  bus_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rd_prev_q, wr_prev_q;
  logic          we_q, we_d;
  logic          rd_fall, wr_fall, wr_rise;
  logic          cnt_en, rdata_en;

  assign rd_fall = rd_act & ~rd_prev_q;
  assign wr_fall = wr_act & ~wr_prev_q;
  assign wr_rise = ~wr_act & wr_prev_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    rdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_act && wr_act) begin
          state_d = ST_CLASH;
        end else if (rd_fall) begin
          state_d = ST_RD_WAIT;
          cnt_d   = CNT_LOAD;
          cnt_en  = 1'b1;
        end else if (wr_fall) begin
          state_d = ST_WR_ACT;
        end
      end
      ST_RD_WAIT: begin
        if (wr_act) begin
          state_d = ST_CLASH;
        end else if (!rd_act) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          state_d  = ST_RD_DONE;
          rdata_en = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_RD_DONE: begin
        if (wr_act) begin
          state_d = ST_CLASH;
        end else if (!rd_act) begin
          state_d = ST_IDLE;
        end
      end
      ST_WR_ACT: begin
        if (rd_act) begin
          state_d = ST_CLASH;
        end else if (!wr_act) begin
          state_d = ST_IDLE;
        end
      end
      ST_CLASH: begin
        if (!rd_act && !wr_act) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdata_d = rdata_en ? reg_rdata : rdata_q;
    we_d    = (state_q == ST_WR_ACT) && wr_rise && !rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_prev_q <= rd_act;
      wr_prev_q <= wr_act;
      we_q      <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign data_out = rdata_q;
  assign data_oe  = (state_q == ST_RD_WAIT) || (state_q == ST_RD_DONE);
  assign ready_n  = !((state_q == ST_RD_DONE) || (state_q == ST_WR_ACT));
  assign we       = we_q;

endmodule

// File: rtl/ibus_regslave.sv
module ibus_regslave
  import hbs_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int RD_LAT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_latch,
  input  logic          rd_strobe_n,
  input  logic          wr_strobe_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_data_in,
  output logic [DW-1:0] host_data_out,
  output logic          host_data_oe,
  output logic          host_ready_n,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);

  localparam logic [STROBE_CNT-1:0] STB_RST = 3'b110;

  logic [STROBE_CNT-1:0] strobe_raw;
  logic [STROBE_CNT-1:0] strobe_sync;
  logic                  ale_act, rd_act, wr_act;

  assign strobe_raw[IDX_ALE] = addr_latch;
  assign strobe_raw[IDX_RD]  = rd_strobe_n;
  assign strobe_raw[IDX_WR]  = wr_strobe_n;

  hbs_strobe_sync #(
    .N       (STROBE_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STB_RST)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (strobe_raw),
    .sync_out (strobe_sync)
  );

  assign ale_act = strobe_sync[IDX_ALE];
  assign rd_act  = ~strobe_sync[IDX_RD];
  assign wr_act  = ~strobe_sync[IDX_WR];

  hbs_sample_hold #(
    .W        (AW),
    .STAGES   (SYNC_STAGES),
    .OPEN_LVL (1'b1)
  ) u_addr_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (host_addr),
    .gate_lvl (ale_act),
    .held_out (reg_addr)
  );

  hbs_sample_hold #(
    .W        (DW),
    .STAGES   (SYNC_STAGES),
    .OPEN_LVL (1'b1)
  ) u_data_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_in   (host_data_in),
    .gate_lvl (wr_act),
    .held_out (reg_wdata)
  );

  hbs_bus_ctrl #(
    .DW     (DW),
    .RD_LAT (RD_LAT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_act    (rd_act),
    .wr_act    (wr_act),
    .reg_rdata (reg_rdata),
    .data_out  (host_data_out),
    .data_oe   (host_data_oe),
    .ready_n   (host_ready_n),
    .we        (reg_we)
  );

endmodule

// File: rtl/ibus_regslave_checker.sv
module ibus_regslave_checker #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale_act,
  input logic          rd_act,
  input logic          wr_act,
  input logic          host_ready_n,
  input logic          host_data_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr
);

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale_act) |-> $stable(reg_addr));

  p_oe_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> $past(rd_act));

  p_we_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_ready_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready_n |-> ($past(rd_act) || $past(wr_act)));

  p_no_we_on_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$past(rd_act));

endmodule

bind ibus_regslave ibus_regslave_checker #(.AW(AW)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .ale_act      (ale_act),
  .rd_act       (rd_act),
  .wr_act       (wr_act),
  .host_ready_n (host_ready_n),
  .host_data_oe (host_data_oe),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr)
);

// File: tb/ibus_regslave_test.sv
`timescale 1ns/1ps
module ibus_regslave_test;

  localparam int AW     = 15;
  localparam int DW     = 8;
  localparam int RD_LAT = 2;
  localparam int NVEC   = 6;
  localparam int WDOG   = 20000;

  localparam logic [AW+DW-1:0] VEC [NVEC] = '{
    {15'h0001, 8'hA5},
    {15'h7FFF, 8'h3C},
    {15'h0020, 8'h00},
    {15'h1234, 8'hFF},
    {15'h0002, 8'h5A},
    {15'h4010, 8'h81}
  };

  logic          clk;
  logic          rst_n;
  logic          addr_latch, rd_strobe_n, wr_strobe_n;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_data_in, host_data_out, reg_wdata, reg_rdata;
  logic          host_data_oe, host_ready_n, reg_we;
  logic [AW-1:0] reg_addr;

  logic [DW-1:0] mem [64];
  logic [DW-1:0] expv [64];
  int            checks, errors, cycles, we_count;
  bit            done;

  ibus_regslave #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_latch    (addr_latch),
    .rd_strobe_n   (rd_strobe_n),
    .wr_strobe_n   (wr_strobe_n),
    .host_addr     (host_addr),
    .host_data_in  (host_data_in),
    .host_data_out (host_data_out),
    .host_data_oe  (host_data_oe),
    .host_ready_n  (host_ready_n),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we),
    .reg_rdata     (reg_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign reg_rdata = mem[reg_addr[5:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      we_count <= 0;
    end else if (reg_we) begin
      mem[reg_addr[5:0]] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic latch_addr(input logic [AW-1:0] a);
    addr_latch = 1'b1;
    host_addr  = a;
    tick(3);
    addr_latch = 1'b0;
    host_addr  = ~a;
    tick(3);
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n, first, pulses;
    latch_addr(a);
    check(reg_addr == a, "R1 addr held after latch fall", reg_addr, a);
    wr_strobe_n  = 1'b0;
    host_data_in = d;
    n = 0;
    do begin
      tick(1);
      n++;
    end while (host_ready_n && n < 20);
    check(n == 3, "R6 write ready delay", n, 3);
    tick(2);
    wr_strobe_n  = 1'b1;
    host_data_in = ~d;
    first  = 0;
    pulses = 0;
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      if (reg_we) begin
        pulses++;
        if (first == 0) begin
          first = k;
          check(reg_wdata == d, "R5 write data", reg_wdata, d);
          check(reg_addr == a, "R5 write address", reg_addr, a);
        end
      end
      if (k == 3) check(host_ready_n == 1'b1, "R6 ready high after write", host_ready_n, 1);
    end
    check(first == 3, "R5 write pulse delay", first, 3);
    check(pulses == 1, "R5 single pulse", pulses, 1);
    expv[a[5:0]] = d;
  endtask

  task automatic host_read(input logic [AW-1:0] a, input string tag);
    int n;
    latch_addr(a);
    rd_strobe_n = 1'b0;
    n = 0;
    do begin
      tick(1);
      n++;
    end while (host_ready_n && n < 20);
    check(n == RD_LAT + 3, "R4 read ready delay", n, RD_LAT + 3);
    check(host_data_oe == 1'b1, "R3 drive during read", host_data_oe, 1);
    check(host_data_out == expv[a[5:0]], tag, host_data_out, expv[a[5:0]]);
    rd_strobe_n = 1'b1;
    tick(3);
    check(host_data_oe == 1'b0, "R3 release after read", host_data_oe, 0);
    check(host_ready_n == 1'b1, "R6 ready high after read", host_ready_n, 1);
  endtask

  initial begin
    int wc;
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    for (int i = 0; i < 64; i++) expv[i] = '0;
    rst_n = 1'b0;
    addr_latch = 1'b0; rd_strobe_n = 1'b1; wr_strobe_n = 1'b1;
    host_addr = '0; host_data_in = '0;
    tick(3);
    check(host_ready_n == 1'b1, "R8 ready in reset", host_ready_n, 1);
    check(host_data_oe == 1'b0, "R8 oe in reset", host_data_oe, 0);
    check(reg_we == 1'b0, "R8 we in reset", reg_we, 0);
    rst_n = 1'b1;
    tick(2);
    check(reg_addr == '0, "R8 addr after reset", reg_addr, 0);
    check(host_ready_n == 1'b1, "R8 ready idle", host_ready_n, 1);

    for (int v = 0; v < NVEC; v++) host_write(VEC[v][AW+DW-1:DW], VEC[v][DW-1:0]);
    for (int v = NVEC - 1; v >= 0; v--) host_read(VEC[v][AW+DW-1:DW], "R3 read data");

    // R2: address follows bus while latch is high
    addr_latch = 1'b1;
    host_addr  = 15'h0155;
    tick(3);
    check(reg_addr == 15'h0155, "R2 track first", reg_addr, 15'h0155);
    host_addr = 15'h2AAA;
    tick(2);
    check(reg_addr == 15'h0155, "R2 track lag", reg_addr, 15'h0155);
    tick(1);
    check(reg_addr == 15'h2AAA, "R2 track second", reg_addr, 15'h2AAA);
    addr_latch = 1'b0;
    host_addr  = 15'h0000;
    tick(6);
    check(reg_addr == 15'h2AAA, "R1 hold after fall", reg_addr, 15'h2AAA);

    // R7: both strobes at once
    latch_addr(15'h0001);
    wc = we_count;
    rd_strobe_n  = 1'b0;
    wr_strobe_n  = 1'b0;
    host_data_in = 8'h77;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      check(host_ready_n == 1'b1 && host_data_oe == 1'b0, "R7 clash quiet",
            {host_ready_n, host_data_oe}, 2'b10);
    end
    rd_strobe_n = 1'b1;
    wr_strobe_n = 1'b1;
    tick(6);
    check(we_count == wc, "R7 no write on clash", we_count, wc);
    host_read(15'h0001, "R7 register unchanged");

    // R5 again with back-to-back write and read to same address
    host_write(15'h0002, 8'hC3);
    host_read(15'h0002, "R5 readback");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule